// File: doc/BRIEF.md
# Genlock Frame Buffer Pointer Controller

This block picks the frame buffer, out of a ring of `NUM_FRAMES` buffers, that a video write or read channel uses for each new frame, and it decides the cycle in which each frame begins. A frame begins on a start event. In free-run the start event is implicit. In edge mode it is a falling edge on an external sync line. In start-of-frame mode it is a high stream user bit. A frame ends on the frame-done strobe. The block only produces the buffer index. Address generation, bursts and line buffering are handled by the logic that consumes the index.

The channel can run as a static master, a static slave, a dynamic master or a dynamic slave. It exchanges frame pointers with a peer channel through `peer_ptr_in` and `ptr_out`. A static slave trails the peer by a programmable delay. A dynamic master steps around the buffer that the peer holds. A dynamic slave takes the peer's completed-frame index. When `genlock_en` is low, the channel runs as a free-running static master whatever the mode select says. A read-channel build also drives a one-cycle start-of-frame user bit when it runs in free-run.

Top module: `genlock_ptr_ctrl`

## Requirements
- R1: After reset, `active_idx`, `ptr_out`, `busy`, `frame_start` and `sof_user0` are all 0, and `busy` stays 0 until the first start event.
- R2: With `sync_sel` = 0 or 3 (free-run), a frame starts in any cycle where the channel is idle, or where `frame_done` is high while `busy` is 1. In the second case the next frame follows with no idle cycle. `frame_start` is high in the cycle after each start, and `busy` is 1 from then until a `frame_done` that has no start with it.
- R3: With `sync_sel` = 1, a frame starts only in a cycle where `fsync_in` is low and it was high in the previous cycle. A rising edge, or a held level, starts nothing.
- R4: With `sync_sel` = 2, a frame starts in a cycle where `sof_in` is high.
- R5: Static master (`gl_mode` = 0): the first frame after reset uses index 0, and each later frame uses the previous index plus 1, wrapping to 0 after `NUM_FRAMES`-1. `ptr_out` carries the new index from the start of the frame.
- R6: Static slave (`gl_mode` = 1): the new index is (`peer_ptr_in` − `frame_delay`) mod `NUM_FRAMES`. Both operands are first reduced mod `NUM_FRAMES`. `ptr_out` carries the new index.
- R7: Dynamic master (`gl_mode` = 2): the candidate index is chosen as in R5. If it equals `peer_ptr_in` mod `NUM_FRAMES`, the next index after it is used instead, so the new index never equals the peer's index. `ptr_out` is loaded with the index of the frame that completes, in the cycle after its `frame_done`.
- R8: Dynamic slave (`gl_mode` = 3): the new index is `peer_ptr_in` mod `NUM_FRAMES`, and `ptr_out` carries it.
- R9: With `genlock_en` = 0, the channel behaves as in R5 for every value of `gl_mode`.
- R10: `active_idx` and `ptr_out` change only in the cycle after a start or a completed frame. A start event that arrives while `busy` is 1 and `frame_done` is 0 is ignored.
- R11: In a read-channel build (`IS_READ` = 1), `sof_user0` is high for exactly the cycle after each start taken with free-run selected. It stays low for starts in the other sync modes.
- R12: When `NUM_FRAMES` is 1, `active_idx` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| genlock_en | input | 1 | Enables synchronisation with the peer pointer |
| gl_mode | input | 2 | 0 static master, 1 static slave, 2 dynamic master, 3 dynamic slave |
| sync_sel | input | 2 | 0 or 3 free-run, 1 sync falling edge, 2 stream start-of-frame |
| frame_delay | input | DLY_W | Slave frame offset, taken mod NUM_FRAMES |
| fsync_in | input | 1 | External frame sync line |
| sof_in | input | 1 | Stream start-of-frame user bit |
| frame_done | input | 1 | Current frame has completed |
| peer_ptr_in | input | PTR_W | Frame pointer from the peer channel |
| ptr_out | output | PTR_W | Registered frame pointer for the peer channel |
| active_idx | output | PTR_W | Buffer index of the current frame |
| busy | output | 1 | A frame is in progress |
| frame_start | output | 1 | One-cycle pulse after each start |
| sof_user0 | output | 1 | Read-channel start-of-frame user bit in free-run |

## Verification
Every result is registered once. A start event or frame-done strobe seen at clock edge k shows up on `active_idx`, `ptr_out`, `busy`, `frame_start` and `sof_user0` just after edge k. The only exception is the sync falling edge: its detector compares the line with the value it had at edge k−1, so the start lands one edge after `fsync_in` drops. The bench drives inputs on falling edges. A behavioural model built from integers takes the same edge and computes the expected outputs, and every output is compared 1 ns after each rising edge. Directed phases cover each mode, each sync source, the delay wrap and the collision skip. A long pseudo-random phase then changes modes and inputs in the middle of frames.

// File: rtl/gpc_pkg.sv
`timescale 1ns/1ps
package gpc_pkg;

    typedef enum logic [1:0] {
        GL_MASTER     = 2'd0,
        GL_SLAVE      = 2'd1,
        GL_DYN_MASTER = 2'd2,
        GL_DYN_SLAVE  = 2'd3
    } gl_mode_e;

    typedef enum logic [1:0] {
        SYNC_FREE  = 2'd0,
        SYNC_EDGE  = 2'd1,
        SYNC_SOF   = 2'd2,
        SYNC_FREE2 = 2'd3
    } sync_sel_e;

endpackage

// File: rtl/gpc_trigger.sv
`timescale 1ns/1ps
module gpc_trigger
    import gpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sync_sel,
    input  logic       fsync_in,
    input  logic       sof_in,
    output logic       trig_o,
    output logic       free_o
);

    typedef struct packed {
        logic fs_prev;
    } trig_st_t;

    trig_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.fs_prev = fsync_in;
        trig_o       = 1'b1;
        free_o       = 1'b0;
        case (sync_sel_e'(sync_sel))
            SYNC_EDGE: trig_o = st_q.fs_prev & ~fsync_in;
            SYNC_SOF:  trig_o = sof_in;
            default: begin
                trig_o = 1'b1;
                free_o = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/gpc_index_pick.sv
`timescale 1ns/1ps
module gpc_index_pick
    import gpc_pkg::*;
#(
    parameter int NUM_FRAMES = 3,
    parameter int PTR_W      = 2,
    parameter int DLY_W      = 5
) (
    input  logic [1:0]       mode_i,
    input  logic             first_i,
    input  logic [PTR_W-1:0] cur_i,
    input  logic [PTR_W-1:0] peer_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic [PTR_W-1:0] next_o
);

    localparam int CW = ((DLY_W > PTR_W) ? DLY_W : PTR_W) + 2;
    localparam logic [CW-1:0] NF = CW'(NUM_FRAMES);

    generate
        if (NUM_FRAMES == 1) begin : g_single
            assign next_o = '0;
        end else begin : g_ring
            logic [CW-1:0] peer_w, dly_w, inc_w, pick_w;

            always_comb begin
                peer_w = CW'(peer_i) % NF;
                dly_w  = CW'(delay_i) % NF;
                if (first_i)                    inc_w = '0;
                else if (CW'(cur_i) == NF - 1)  inc_w = '0;
                else                            inc_w = CW'(cur_i) + 1'b1;

                case (gl_mode_e'(mode_i))
                    GL_SLAVE: begin
                        pick_w = peer_w + NF - dly_w;
                        if (pick_w >= NF) pick_w = pick_w - NF;
                    end
                    GL_DYN_MASTER: begin
                        pick_w = inc_w;
                        if (pick_w == peer_w)
                            pick_w = (pick_w == NF - 1) ? '0 : pick_w + 1'b1;
                    end
                    GL_DYN_SLAVE: pick_w = peer_w;
                    default:      pick_w = inc_w;
                endcase
                next_o = pick_w[PTR_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/genlock_ptr_ctrl.sv
`timescale 1ns/1ps
module genlock_ptr_ctrl
    import gpc_pkg::*;
#(
    parameter int  NUM_FRAMES = 3,
    parameter bit  IS_READ    = 1'b1,
    parameter int  DLY_W      = 5,
    localparam int PTR_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             genlock_en,
    input  logic [1:0]       gl_mode,
    input  logic [1:0]       sync_sel,
    input  logic [DLY_W-1:0] frame_delay,
    input  logic             fsync_in,
    input  logic             sof_in,
    input  logic             frame_done,
    input  logic [PTR_W-1:0] peer_ptr_in,
    output logic [PTR_W-1:0] ptr_out,
    output logic [PTR_W-1:0] active_idx,
    output logic             busy,
    output logic             frame_start,
    output logic             sof_user0
);

    typedef struct packed {
        logic             busy;
        logic             started;
        logic [PTR_W-1:0] active;
        logic [PTR_W-1:0] ptr;
        logic             start_p;
        logic             sof_p;
    } ctrl_st_t;

    ctrl_st_t   st_d, st_q;
    logic       trig, free_sel;
    logic       start_evt, done_evt, sof_cand;
    gl_mode_e   eff_mode;
    logic [PTR_W-1:0] next_idx;

    gpc_trigger u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_sel (sync_sel),
        .fsync_in (fsync_in),
        .sof_in   (sof_in),
        .trig_o   (trig),
        .free_o   (free_sel)
    );

    assign eff_mode = genlock_en ? gl_mode_e'(gl_mode) : GL_MASTER;

    gpc_index_pick #(
        .NUM_FRAMES (NUM_FRAMES),
        .PTR_W      (PTR_W),
        .DLY_W      (DLY_W)
    ) u_pick (
        .mode_i  (eff_mode),
        .first_i (~st_q.started),
        .cur_i   (st_q.active),
        .peer_i  (peer_ptr_in),
        .delay_i (frame_delay),
        .next_o  (next_idx)
    );

    assign done_evt  = st_q.busy & frame_done;
    assign start_evt = trig & (~st_q.busy | frame_done);

    generate
        if (IS_READ) begin : g_read
            assign sof_cand = start_evt & free_sel;
        end else begin : g_write
            assign sof_cand = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d         = st_q;
        st_d.start_p = start_evt;
        st_d.sof_p   = sof_cand;
        if (start_evt) begin
            st_d.busy    = 1'b1;
            st_d.started = 1'b1;
            st_d.active  = next_idx;
            if (eff_mode != GL_DYN_MASTER) st_d.ptr = next_idx;
        end else if (done_evt) begin
            st_d.busy = 1'b0;
        end
        if (done_evt && eff_mode == GL_DYN_MASTER) st_d.ptr = st_q.active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_out     = st_q.ptr;
    assign active_idx  = st_q.active;
    assign busy        = st_q.busy;
    assign frame_start = st_q.start_p;
    assign sof_user0   = st_q.sof_p;

endmodule

// File: rtl/gpc_checker.sv
`timescale 1ns/1ps
module gpc_checker #(
    parameter int NUM_FRAMES = 3,
    parameter int PTR_W      = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_evt,
    input logic             done_evt,
    input logic             genlock_en,
    input logic [1:0]       gl_mode,
    input logic [1:0]       sync_sel,
    input logic [PTR_W-1:0] peer_ptr_in,
    input logic [PTR_W-1:0] ptr_out,
    input logic [PTR_W-1:0] active_idx,
    input logic             busy,
    input logic             sof_user0
);

    p_hold_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_evt && !done_evt) |=> ($stable(ptr_out) && $stable(active_idx)));

    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(active_idx) < NUM_FRAMES);

    p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_evt));

    p_sof_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sof_user0 |-> ($past(sync_sel) == 2'd0 || $past(sync_sel) == 2'd3));

    generate
        if (NUM_FRAMES > 1) begin : g_multi
            p_dyn_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (start_evt && genlock_en && gl_mode == 2'd2)
                |=> (int'(active_idx) != (int'($past(peer_ptr_in)) % NUM_FRAMES)));
        end else begin : g_one
            p_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
                active_idx == '0);
        end
    endgenerate

endmodule

bind genlock_ptr_ctrl gpc_checker #(
    .NUM_FRAMES (NUM_FRAMES),
    .PTR_W      (PTR_W)
) u_gpc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt   (start_evt),
    .done_evt    (done_evt),
    .genlock_en  (genlock_en),
    .gl_mode     (gl_mode),
    .sync_sel    (sync_sel),
    .peer_ptr_in (peer_ptr_in),
    .ptr_out     (ptr_out),
    .active_idx  (active_idx),
    .busy        (busy),
    .sof_user0   (sof_user0)
);

// File: tb/genlock_ptr_ctrl_tb_top.sv
`timescale 1ns/1ps
module genlock_ptr_ctrl_tb_top;

    localparam int NF = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       genlock_en = 1'b1;
    logic [1:0] gl_mode = 2'd0;
    logic [1:0] sync_sel = 2'd1;
    logic [4:0] frame_delay = 5'd0;
    logic       fsync_in = 1'b0;
    logic       sof_in = 1'b0;
    logic       frame_done = 1'b0;
    logic [1:0] peer_ptr_in = 2'd0;
    logic [1:0] ptr_out, active_idx;
    logic       busy, frame_start, sof_user0;
    logic [0:0] n1_ptr, n1_idx;
    logic       n1_busy, n1_start, n1_sof;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    genlock_ptr_ctrl #(.NUM_FRAMES(NF), .IS_READ(1'b1), .DLY_W(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .genlock_en(genlock_en), .gl_mode(gl_mode),
        .sync_sel(sync_sel), .frame_delay(frame_delay), .fsync_in(fsync_in),
        .sof_in(sof_in), .frame_done(frame_done), .peer_ptr_in(peer_ptr_in),
        .ptr_out(ptr_out), .active_idx(active_idx), .busy(busy),
        .frame_start(frame_start), .sof_user0(sof_user0)
    );

    genlock_ptr_ctrl #(.NUM_FRAMES(1), .IS_READ(1'b1), .DLY_W(5)) dut_n1 (
        .clk(clk), .rst_n(rst_n), .genlock_en(genlock_en), .gl_mode(gl_mode),
        .sync_sel(sync_sel), .frame_delay(frame_delay), .fsync_in(fsync_in),
        .sof_in(sof_in), .frame_done(frame_done), .peer_ptr_in(peer_ptr_in[0:0]),
        .ptr_out(n1_ptr), .active_idx(n1_idx), .busy(n1_busy),
        .frame_start(n1_start), .sof_user0(n1_sof)
    );

    // behavioural reference model
    int m_act, m_ptr, m_busy, m_started, m_fprev, m_start, m_sof;

    always @(posedge clk) begin
        int trig, done, st, em, nxt, sel, peer;
        if (!rst_n) begin
            m_act = 0; m_ptr = 0; m_busy = 0; m_started = 0;
            m_fprev = 0; m_start = 0; m_sof = 0;
        end else begin
            sel  = int'(sync_sel);
            peer = int'(peer_ptr_in) % NF;
            if (sel == 1)      trig = (m_fprev == 1 && fsync_in == 1'b0) ? 1 : 0;
            else if (sel == 2) trig = sof_in ? 1 : 0;
            else               trig = 1;
            done = (m_busy == 1 && frame_done) ? 1 : 0;
            st   = (trig == 1 && (m_busy == 0 || frame_done)) ? 1 : 0;
            em   = genlock_en ? int'(gl_mode) : 0;
            nxt  = (m_started == 0) ? 0 : (m_act + 1) % NF;
            if (em == 1) nxt = (peer - (int'(frame_delay) % NF) + NF) % NF;
            if (em == 2 && nxt == peer) nxt = (nxt + 1) % NF;
            if (em == 3) nxt = peer;
            if (done == 1 && em == 2) m_ptr = m_act;
            if (st == 1) begin
                m_act = nxt; m_busy = 1; m_started = 1;
                if (em != 2) m_ptr = nxt;
            end else if (done == 1) begin
                m_busy = 0;
            end
            m_start = st;
            m_sof   = (st == 1 && (sel == 0 || sel == 3)) ? 1 : 0;
            m_fprev = fsync_in ? 1 : 0;
        end
    end

    task automatic cmp(input string what, input int got, input int exp, inout bit bad);
        if (got != exp) begin
            $display("FAIL %s %s: got %0d expected %0d at %0t", cur_req, what, got, exp, $time);
            bad = 1;
        end
    endtask

    always @(posedge clk) begin
        bit bad;
        #1;
        if (!finished) begin
            bad = 0;
            vectors++;
            cmp("active_idx", int'(active_idx), m_act, bad);
            cmp("ptr_out", int'(ptr_out), m_ptr, bad);
            cmp("busy", int'(busy), m_busy, bad);
            cmp("frame_start", int'(frame_start), m_start, bad);
            cmp("sof_user0", int'(sof_user0), m_sof, bad);
            if (n1_idx != 1'b0) begin
                $display("FAIL R12 single-buffer index: got %0d expected 0", n1_idx);
                bad = 1;
            end
            if (bad) miscompares++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edge_frame(input int len);
        fsync_in = 1'b1; tick(2);
        fsync_in = 1'b0; tick(len);
        frame_done = 1'b1; tick(1);
        frame_done = 1'b0; tick(1);
    endtask

    task automatic direct_check(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s direct: got %0d expected %0d", req, got, exp);
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        tick(4);
        cur_req = "R1";
        rst_n = 1'b1;
        tick(4);
        direct_check("R1", int'(busy), 0);
        direct_check("R1", int'(active_idx), 0);

        cur_req = "R3";
        fsync_in = 1'b1; tick(4);
        direct_check("R3", int'(busy), 0);
        fsync_in = 1'b0; tick(1);
        direct_check("R3", int'(busy), 1);
        frame_done = 1'b1; tick(1); frame_done = 1'b0; tick(1);

        cur_req = "R5";
        repeat (4) edge_frame(3);
        direct_check("R5", int'(active_idx), 1);

        cur_req = "R10";
        fsync_in = 1'b1; tick(2); fsync_in = 1'b0; tick(2);
        fsync_in = 1'b1; tick(2); fsync_in = 1'b0; tick(2);
        direct_check("R10", int'(active_idx), 2);
        frame_done = 1'b1; tick(1); frame_done = 1'b0; tick(1);

        cur_req = "R6";
        gl_mode = 2'd1; peer_ptr_in = 2'd2; frame_delay = 5'd1;
        edge_frame(2);
        direct_check("R6", int'(active_idx), 1);
        peer_ptr_in = 2'd0; frame_delay = 5'd4;
        edge_frame(2);
        direct_check("R6", int'(active_idx), 2);

        cur_req = "R7";
        gl_mode = 2'd2; peer_ptr_in = 2'd0;
        edge_frame(2);
        direct_check("R7", int'(active_idx), 1);
        direct_check("R7", int'(ptr_out), 1);
        peer_ptr_in = 2'd2;
        edge_frame(2);
        direct_check("R7", int'(active_idx), 0);

        cur_req = "R8";
        gl_mode = 2'd3; peer_ptr_in = 2'd2;
        edge_frame(2);
        direct_check("R8", int'(active_idx), 2);

        cur_req = "R9";
        genlock_en = 1'b0; gl_mode = 2'd1;
        edge_frame(2);
        direct_check("R9", int'(active_idx), 0);
        genlock_en = 1'b1;

        cur_req = "R4";
        gl_mode = 2'd0; sync_sel = 2'd2;
        sof_in = 1'b1; tick(1); sof_in = 1'b0; tick(3);
        frame_done = 1'b1; tick(1); frame_done = 1'b0; tick(2);
        direct_check("R4", int'(active_idx), 1);

        cur_req = "R2";
        sync_sel = 2'd0; tick(3);
        frame_done = 1'b1; tick(3); frame_done = 1'b0; tick(3);
        cur_req = "R11";
        repeat (3) begin frame_done = 1'b1; tick(1); frame_done = 1'b0; tick(2); end

        cur_req = "R10";
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            fsync_in    = lfsr[0];
            sof_in      = lfsr[1] & lfsr[2];
            frame_done  = lfsr[3] & lfsr[4];
            peer_ptr_in = lfsr[6:5];
            if (lfsr[9:7] == 3'd0) gl_mode = lfsr[11:10];
            if (lfsr[12:10] == 3'd1) sync_sel = lfsr[14:13];
            if (lfsr[15:13] == 3'd2) genlock_en = lfsr[8];
            frame_delay = lfsr[15:11];
            tick(1);
        end
        tick(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule